// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port with a small memory-mapped register interface. It can drive each pin with a data value, sample each pin's level, and watch selected pins for an interrupt trigger. The trigger for each pin is one of four kinds: low level, high level, falling edge or rising edge. Detected events are held in a pending-flag register until software acknowledges them. A per-pin mask decides which pending flags reach the single combined interrupt line.

Every writable register occupies three consecutive word addresses. The base address loads the whole word. Base+4 sets only the bits written as one. Base+8 clears only the bits written as one. Because of this, software never needs a read-modify-write to change one pin. A pair of pattern registers serves two purposes: it selects the trigger kind for interrupt pins, and one of the pair gives the output data for all other pins. Pin multiplexing, pulls and output enables belong to a separate pin controller and are not part of this block.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the mask register reads all ones; the function-select, pattern-1, pattern-0 and flag registers read zero; `irq` and `pin_out` are zero.
- R2: A write to a register's base offset loads it. A write to base+4 ORs the written ones into it. A write to base+8 clears the written ones. All other bits are unchanged.
- R3: Reads decode the function select at 0x10, the mask at 0x20, pattern-1 at 0x30, pattern-0 at 0x40 and the flags at 0x50. A read of any other address, including the +4 and +8 aliases, returns zero.
- R4: A read at 0x00 returns the pin levels after a two-flop synchroniser: a pin change made before clock edge k is visible after edge k+1 and not after edge k. Writes to 0x00 have no effect.
- R5: `pin_out[i]` equals pattern-0 bit i while function-select bit i is 0, and is 0 while that bit is 1.
- R6: With function-select bit i set, the trigger code {pattern-1[i], pattern-0[i]} means 00 low level, 01 high level, 10 falling edge, 11 rising edge. An edge sets flag i, and the flag stays set after the pin returns, until it is cleared.
- R7: A level trigger sets its flag on every cycle that the level holds, so a clear issued while the level holds does not remove the flag.
- R8: A pin whose function-select bit is 0 never sets its flag, whatever its level or edges.
- R9: `irq` is a register that is high one cycle after any pin has flag, function select and NOT mask all high. A set mask bit keeps that pin from raising `irq`.
- R10: Writing a one to 0x58 acknowledges (clears) that pin's flag once the trigger condition is gone, and `irq` falls on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data (combinational, valid while selected) |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output data per pin |
| irq | output | 1 | Combined, registered interrupt request |

## Verification
The bench builds the port with its default of 32 pins and a two-stage synchroniser. The full word width therefore checks that the set and clear aliases and the read decode handle the top and bottom bits alike. The fixed synchroniser depth allows an exact check of the cycle in which a pin change first becomes readable and in which a flag and `irq` rise. All four trigger codes are exercised on separate pins, together with the mask gate and the difference between a sticky edge flag and a level flag that re-asserts.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int unsigned ADDR_W = 8;

    localparam logic [3:0] BLK_PIN  = 4'h0;
    localparam logic [3:0] BLK_FUNC = 4'h1;
    localparam logic [3:0] BLK_MASK = 4'h2;
    localparam logic [3:0] BLK_PAT1 = 4'h3;
    localparam logic [3:0] BLK_PAT0 = 4'h4;
    localparam logic [3:0] BLK_FLAG = 4'h5;

    localparam logic [3:0] SUB_LOAD = 4'h0;
    localparam logic [3:0] SUB_SET  = 4'h4;
    localparam logic [3:0] SUB_CLR  = 4'h8;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_LOAD,
        OP_SET,
        OP_CLR
    } wr_op_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PIN,
        RG_FUNC,
        RG_MASK,
        RG_PAT1,
        RG_PAT0,
        RG_FLAG
    } reg_id_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= stg_d[s];
            end
        end
    end

    assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_irq_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_id_e           wr_id,
    output wr_op_e            wr_op,
    output reg_id_e           rd_id
);
    reg_id_e blk_id;
    logic [3:0] blk;
    logic [3:0] sub;

    assign blk = bus_addr[7:4];
    assign sub = bus_addr[3:0];

    always_comb begin
        case (blk)
            BLK_PIN:  blk_id = RG_PIN;
            BLK_FUNC: blk_id = RG_FUNC;
            BLK_MASK: blk_id = RG_MASK;
            BLK_PAT1: blk_id = RG_PAT1;
            BLK_PAT0: blk_id = RG_PAT0;
            BLK_FLAG: blk_id = RG_FLAG;
            default:  blk_id = RG_NONE;
        endcase
    end

    always_comb begin
        wr_id = RG_NONE;
        wr_op = OP_NONE;
        rd_id = RG_NONE;
        if (bus_sel && bus_we && blk_id != RG_PIN && blk_id != RG_NONE) begin
            wr_id = blk_id;
            case (sub)
                SUB_LOAD: wr_op = OP_LOAD;
                SUB_SET:  wr_op = OP_SET;
                SUB_CLR:  wr_op = OP_CLR;
                default:  wr_op = OP_NONE;
            endcase
        end
        if (bus_sel && !bus_we && sub == SUB_LOAD) begin
            rd_id = blk_id;
        end
    end
endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] func,
    input  logic [NPINS-1:0] pat1,
    input  logic [NPINS-1:0] pat0,
    output logic [NPINS-1:0] hit
);
    logic [NPINS-1:0] prev_d;
    logic [NPINS-1:0] prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic raw;
        always_comb begin
            case ({pat1[i], pat0[i]})
                2'b00:   raw = ~lvl[i];
                2'b01:   raw = lvl[i];
                2'b10:   raw = prev_q[i] & ~lvl[i];
                default: raw = ~prev_q[i] & lvl[i];
            endcase
        end
        assign hit[i] = raw & func[i];
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic              irq
);
    typedef struct packed {
        logic [NPINS-1:0] func;
        logic [NPINS-1:0] mask;
        logic [NPINS-1:0] pat1;
        logic [NPINS-1:0] pat0;
        logic [NPINS-1:0] flag;
        logic             irq;
    } state_t;

    state_t st_d;
    state_t st_q;

    reg_id_e          wr_id;
    wr_op_e           wr_op;
    reg_id_e          rd_id;
    logic [NPINS-1:0] lvl;
    logic [NPINS-1:0] hit;

    logic [NPINS-1:0] func_q;
    logic [NPINS-1:0] mask_q;
    logic [NPINS-1:0] pat0_q;
    logic [NPINS-1:0] flag_q;

    function automatic logic [NPINS-1:0] apply_op(
        input logic [NPINS-1:0] cur,
        input wr_op_e           op,
        input logic [NPINS-1:0] val
    );
        case (op)
            OP_LOAD: return val;
            OP_SET:  return cur | val;
            OP_CLR:  return cur & ~val;
            default: return cur;
        endcase
    endfunction

    gpio_sync #(
        .WIDTH  (NPINS),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (lvl)
    );

    gpio_bus_decode dec_i (
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .wr_id    (wr_id),
        .wr_op    (wr_op),
        .rd_id    (rd_id)
    );

    gpio_event_detect #(
        .NPINS (NPINS)
    ) det_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .func  (st_q.func),
        .pat1  (st_q.pat1),
        .pat0  (st_q.pat0),
        .hit   (hit)
    );

    always_comb begin
        st_d = st_q;
        case (wr_id)
            RG_FUNC: st_d.func = apply_op(st_q.func, wr_op, bus_wdata);
            RG_MASK: st_d.mask = apply_op(st_q.mask, wr_op, bus_wdata);
            RG_PAT1: st_d.pat1 = apply_op(st_q.pat1, wr_op, bus_wdata);
            RG_PAT0: st_d.pat0 = apply_op(st_q.pat0, wr_op, bus_wdata);
            RG_FLAG: st_d.flag = apply_op(st_q.flag, wr_op, bus_wdata);
            default: ;
        endcase
        // a detected event wins over a same-cycle software clear
        st_d.flag = st_d.flag | hit;
        st_d.irq  = |(st_q.flag & st_q.func & ~st_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (rd_id)
            RG_PIN:  bus_rdata = lvl;
            RG_FUNC: bus_rdata = st_q.func;
            RG_MASK: bus_rdata = st_q.mask;
            RG_PAT1: bus_rdata = st_q.pat1;
            RG_PAT0: bus_rdata = st_q.pat0;
            RG_FLAG: bus_rdata = st_q.flag;
            default: bus_rdata = '0;
        endcase
    end

    assign pin_out = st_q.pat0 & ~st_q.func;
    assign irq     = st_q.irq;

    assign func_q = st_q.func;
    assign mask_q = st_q.mask;
    assign pat0_q = st_q.pat0;
    assign flag_q = st_q.flag;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
    parameter int unsigned NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_we,
    input logic [7:0]       bus_addr,
    input logic [NPINS-1:0] bus_wdata,
    input logic [NPINS-1:0] bus_rdata,
    input logic [NPINS-1:0] pin_out,
    input logic             irq,
    input logic [NPINS-1:0] func_q,
    input logic [NPINS-1:0] mask_q,
    input logic [NPINS-1:0] pat0_q,
    input logic [NPINS-1:0] flag_q
);
    logic flag_wr_any;
    logic flag_wr_up;
    logic pat0_set_wr;

    assign flag_wr_any = bus_sel && bus_we && (bus_addr == 8'h50 || bus_addr == 8'h58 || bus_addr == 8'h54);
    assign flag_wr_up  = bus_sel && bus_we && (bus_addr == 8'h50 || bus_addr == 8'h54);
    assign pat0_set_wr = bus_sel && bus_we && bus_addr == 8'h44;

    // R2: set alias leaves every written one set
    p_set_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pat0_set_wr) |-> ((pat0_q & $past(bus_wdata)) == $past(bus_wdata)));

    // R3: non-base and undecoded reads return zero
    p_undecoded_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr[3:0] != 4'h0) |-> (bus_rdata == '0));

    // R5: interrupt-function pins drive no data
    p_func_pins_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & func_q) == '0));

    // R6: without a flag write no flag bit drops
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(flag_wr_any) |-> ((flag_q & $past(flag_q)) == $past(flag_q)));

    // R8: a new flag bit needs its function-select bit
    p_flag_needs_func_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(flag_wr_up) |-> ((flag_q & ~$past(flag_q) & ~$past(func_q)) == '0));

    // R9: fully masked port keeps irq low
    p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(&mask_q) |-> !irq);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .irq       (irq),
    .func_q    (func_q),
    .mask_q    (mask_q),
    .pat0_q    (pat0_q),
    .flag_q    (flag_q)
);

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;
    localparam int unsigned NPINS = 32;
    localparam int unsigned NVEC  = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_sel = 1'b0;
    logic             bus_we = 1'b0;
    logic [7:0]       bus_addr = '0;
    logic [NPINS-1:0] bus_wdata = '0;
    logic [NPINS-1:0] bus_rdata;
    logic [NPINS-1:0] pin_in = '0;
    logic [NPINS-1:0] pin_out;
    logic             irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    gpio_irq_port #(.NPINS(NPINS), .SYNC_STAGES(2)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .irq       (irq)
    );

    // {tag, write addr, write data, read addr, expected read}
    localparam logic [83:0] VEC [NVEC] = '{
        {4'd2, 8'h30, 32'hA5A5_0000, 8'h30, 32'hA5A5_0000},
        {4'd2, 8'h34, 32'h0000_00FF, 8'h30, 32'hA5A5_00FF},
        {4'd2, 8'h38, 32'hA000_000F, 8'h30, 32'h05A5_00F0},
        {4'd2, 8'h44, 32'h1234_5678, 8'h40, 32'h1234_5678},
        {4'd2, 8'h48, 32'h0000_0078, 8'h40, 32'h1234_5600},
        {4'd2, 8'h28, 32'hFFFF_0000, 8'h20, 32'h0000_FFFF},
        {4'd2, 8'h24, 32'h8001_0000, 8'h20, 32'h8001_FFFF},
        {4'd4, 8'h00, 32'hFFFF_FFFF, 8'h00, 32'h0000_0000},
        {4'd3, 8'h14, 32'h0000_0000, 8'h34, 32'h0000_0000},
        {4'd3, 8'h60, 32'hFFFF_FFFF, 8'h60, 32'h0000_0000},
        {4'd3, 8'h1C, 32'hFFFF_FFFF, 8'h10, 32'h0000_0000}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd2:    return "R2";
            4'd3:    return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string req, input logic [NPINS-1:0] act, input logic [NPINS-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [NPINS-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [NPINS-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [NPINS-1:0] v;
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h20, v); check("R1 mask", v, 32'hFFFF_FFFF);
        rd(8'h10, v); check("R1 func", v, '0);
        rd(8'h30, v); check("R1 pat1", v, '0);
        rd(8'h40, v); check("R1 pat0", v, '0);
        rd(8'h50, v); check("R1 flag", v, '0);
        check("R1 irq", {31'd0, irq}, '0);
        check("R1 pin_out", pin_out, '0);

        // table of register accesses
        for (int k = 0; k < NVEC; k++) begin
            wr(VEC[k][79:72], VEC[k][71:40]);
            rd(VEC[k][39:32], v);
            check(tag_name(VEC[k][83:80]), v, VEC[k][31:0]);
        end

        // R5 data output with function select clear
        check("R5 pin_out", pin_out, 32'h1234_5600);
        wr(8'h30, '0);
        wr(8'h40, '0);
        wr(8'h20, 32'hFFFF_FFFF);
        check("R5 pin_out cleared", pin_out, '0);

        // R4 synchroniser latency
        @(negedge clk);
        pin_in = 32'hDEAD_BEEF;
        rd(8'h00, v); check("R4 one edge", v, '0);
        rd(8'h00, v); check("R4 two edges", v, 32'hDEAD_BEEF);
        pin_in = '0;
        idle(4);

        // R8 pin without function select
        pin_in[4] = 1'b1; idle(4);
        pin_in[4] = 1'b0; idle(4);
        rd(8'h50, v); check("R8 no flag", v, '0);

        // R6 rising edge on pin 0, R9 unmasked
        wr(8'h34, 32'h1);
        wr(8'h44, 32'h1);
        wr(8'h14, 32'h1);
        wr(8'h28, 32'h1);
        idle(3);
        rd(8'h50, v); check("R6 rising idle", v, '0);
        pin_in[0] = 1'b1; idle(5);
        rd(8'h50, v); check("R6 rising flag", v, 32'h1);
        check("R9 irq up", {31'd0, irq}, 32'h1);
        pin_in[0] = 1'b0; idle(5);
        rd(8'h50, v); check("R6 sticky", v, 32'h1);
        wr(8'h58, 32'h1);
        idle(2);
        rd(8'h50, v); check("R10 ack flag", v, '0);
        check("R10 irq down", {31'd0, irq}, '0);

        // R6 falling edge on pin 1, masked then unmasked (R9)
        wr(8'h34, 32'h2);
        wr(8'h14, 32'h2);
        pin_in[1] = 1'b1; idle(5);
        rd(8'h50, v); check("R6 falling ignores rise", v, '0);
        pin_in[1] = 1'b0; idle(5);
        rd(8'h50, v); check("R6 falling flag", v, 32'h2);
        check("R9 masked irq", {31'd0, irq}, '0);
        wr(8'h28, 32'h2);
        idle(2);
        check("R9 unmasked irq", {31'd0, irq}, 32'h1);
        wr(8'h58, 32'h2);
        wr(8'h24, 32'h3);
        idle(2);
        check("R10 irq cleared", {31'd0, irq}, '0);

        // R7 high level on pin 2
        wr(8'h44, 32'h4);
        check("R5 data bit", pin_out, 32'h4);
        wr(8'h14, 32'h4);
        check("R5 func hides data", pin_out, '0);
        pin_in[2] = 1'b1; idle(5);
        rd(8'h50, v); check("R6 high level", v, 32'h4);
        wr(8'h58, 32'h4);
        rd(8'h50, v); check("R7 reassert", v, 32'h4);
        pin_in[2] = 1'b0; idle(4);
        wr(8'h58, 32'h4);
        idle(2);
        rd(8'h50, v); check("R7 released", v, '0);

        // R6 low level on pin 3
        wr(8'h14, 32'h8);
        idle(3);
        rd(8'h50, v); check("R6 low level", v, 32'h8);
        pin_in[3] = 1'b1; idle(4);
        wr(8'h58, 32'h8);
        idle(2);
        rd(8'h50, v); check("R10 low level ack", v, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule